// File: doc/BRIEF.md
# Gated 13-bit timer/counter

This block is one timer/counter channel of a small microcontroller, held in its 13-bit mode. The 13-bit count is split across two byte-wide registers. The high register holds the upper eight bits. Only the five least significant bits of the low register take part, and they act as a divide-by-32 prescaler in front of the high part. The carry out of bit 4 of the low register goes into bit 0 of the high register.

Count steps come from one of two sources. The first is a free-running divide-by-twelve of the system clock. The second is falling edges on an external count pin, which is brought into the clock domain through a two-flop synchroniser. A run control enables counting. When the gate control is set, an external gate pin must also be high, which lets software measure the width of a pulse on that pin.

When the count wraps from all ones to zero, a sticky overflow flag is set. That flag drives the interrupt request. Software can load either count register at any time and can clear the flag.

Top module: `gtc13_timer`

## Requirements
- R1: While reset is asserted and after its release, both count reads are 0, the overflow flag is 0 and the interrupt request is 0.
- R2: The count value is {hi_rd[7:0], lo_rd[4:0]}, and a carry out of lo bit 4 increments the high byte. lo_rd[7:5] always reads 0, and the top three bits written to the low byte are discarded.
- R3: When an enabled step takes the count from 13'h1FFF to 0, the overflow flag is set on that same edge. irq always equals the overflow flag.
- R4: The overflow flag stays set until ovf_clr is applied, and ovf_clr clears it on the next edge. If a clear and a wrap fall on the same edge, the flag ends up set.
- R5: The count moves only when run_en=1 and either gate_en=0 or gate_pin=1. gate_pin is a synchronous input sampled at the clock edge.
- R6: With ext_sel=0 the count advances exactly N times in any window of 12*N enabled clock cycles, whatever the phase.
- R7: With ext_sel=1 the count advances once for each 1-to-0 transition of cnt_pin, at most three clocks after the transition. Rising edges, a steady level and the internal divider have no effect.
- R8: A write strobe (hi_wr or lo_wr) loads wr_data into that byte on the next edge and overrides any step in that cycle. Turning run_en off and on again does not clear the count, so counting resumes from the value held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run control; 1 allows counting |
| gate_en | input | 1 | Gate control; 1 makes counting depend on gate_pin |
| ext_sel | input | 1 | Step source: 0 = clock divided by 12, 1 = falling edges of cnt_pin |
| gate_pin | input | 1 | External gate level, synchronous |
| cnt_pin | input | 1 | External count input, asynchronous |
| hi_wr | input | 1 | Write strobe for the high count byte |
| lo_wr | input | 1 | Write strobe for the low count byte |
| wr_data | input | 8 | Write data for either count byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| hi_rd | output | 8 | High count byte |
| lo_rd | output | 8 | Low count byte, bits 7:5 read 0 |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request, follows ovf_flag |

## Verification
The bench loads start values whose low five bits sit just below 31. A design that carries out of bit 7 instead of bit 4, or that lets the top three written bits count, ends up with a wrong high byte. It holds ovf_clr high across a wrap, where a design that gives priority to the clear drops an overflow that should be reported. It writes the count on twelve consecutive cycles while the counter is running, so one write is certain to coincide with a divider tick, and a design that lets the increment win returns the written value plus one. In counter mode it checks that only falling edges count, and that the internal divider no longer steps the count once the external source is selected.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
   typedef enum logic {
      SRC_DIV = 1'b0,
      SRC_PIN = 1'b1
   } gtc_src_e;
endpackage

// File: rtl/gtc_tick_div.sv
module gtc_tick_div #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad
         $error("gtc_tick_div: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_mod
         logic [CW-1:0] phase_q;
         assign tick = (phase_q == CW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    phase_q <= '0;
            else if (tick) phase_q <= '0;
            else           phase_q <= phase_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/gtc_edge_sync.sv
module gtc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gtc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[STAGES-1:0], pin};
   end

   assign fall = shift_q[STAGES] & ~shift_q[STAGES-1];
endmodule

// File: rtl/gtc_count_core.sv
module gtc_count_core #(
   parameter int HI_W   = 8,
   parameter int LO_W   = 5,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ovf_clr,
   output logic [HI_W-1:0]   hi_q,
   output logic [LO_W-1:0]   lo_q,
   output logic              ovf_q
);
   localparam int CW = HI_W + LO_W;

   logic          any_wr;
   logic          wrap;
   logic [CW-1:0] nxt;

   assign any_wr = hi_wr | lo_wr;
   assign nxt    = {hi_q, lo_q} + 1'b1;
   assign wrap   = step & ~any_wr & (&{hi_q, lo_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (any_wr) begin
         if (hi_wr) hi_q <= wr_data[HI_W-1:0];
         if (lo_wr) lo_q <= wr_data[LO_W-1:0];
      end else if (step) begin
         {hi_q, lo_q} <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (wrap)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
   end
endmodule

// File: rtl/gtc13_timer.sv
module gtc13_timer #(
   parameter int HI_W        = 8,
   parameter int LO_W        = 5,
   parameter int BYTE_W      = 8,
   parameter int CLK_DIV     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              gate_en,
   input  logic              ext_sel,
   input  logic              gate_pin,
   input  logic              cnt_pin,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ovf_clr,
   output logic [BYTE_W-1:0] hi_rd,
   output logic [BYTE_W-1:0] lo_rd,
   output logic              ovf_flag,
   output logic              irq
);
   import gtc_pkg::*;

   generate
      if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_hi
         $error("gtc13_timer: HI_W must lie in 1..BYTE_W");
      end
      if (LO_W < 1 || LO_W > BYTE_W) begin : g_bad_lo
         $error("gtc13_timer: LO_W must lie in 1..BYTE_W");
      end
   endgenerate

   logic            div_tick;
   logic            pin_fall;
   logic            src_tick;
   logic            gate_ok;
   logic            step;
   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;

   gtc_tick_div #(.DIV(CLK_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (div_tick)
   );

   gtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cnt_pin),
      .fall  (pin_fall)
   );

   assign src_tick = (gtc_src_e'(ext_sel) == SRC_PIN) ? pin_fall : div_tick;
   assign gate_ok  = ~gate_en | gate_pin;
   assign step     = run_en & gate_ok & src_tick;

   gtc_count_core #(.HI_W(HI_W), .LO_W(LO_W), .BYTE_W(BYTE_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .hi_wr   (hi_wr),
      .lo_wr   (lo_wr),
      .wr_data (wr_data),
      .ovf_clr (ovf_clr),
      .hi_q    (hi_q),
      .lo_q    (lo_q),
      .ovf_q   (ovf_flag)
   );

   generate
      if (HI_W < BYTE_W) begin : g_hi_pad
         assign hi_rd = {{(BYTE_W-HI_W){1'b0}}, hi_q};
      end else begin : g_hi_full
         assign hi_rd = hi_q;
      end
      if (LO_W < BYTE_W) begin : g_lo_pad
         assign lo_rd = {{(BYTE_W-LO_W){1'b0}}, lo_q};
      end else begin : g_lo_full
         assign lo_rd = lo_q;
      end
   endgenerate

   assign irq = ovf_flag;
endmodule

// File: rtl/gtc13_timer_chk.sv
module gtc13_timer_chk #(
   parameter int HI_W   = 8,
   parameter int LO_W   = 5,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              gate_en,
   input logic              gate_pin,
   input logic              hi_wr,
   input logic              lo_wr,
   input logic [BYTE_W-1:0] wr_data,
   input logic              ovf_clr,
   input logic [BYTE_W-1:0] hi_rd,
   input logic [BYTE_W-1:0] lo_rd,
   input logic              ovf_flag,
   input logic              irq
);
   localparam int CW = HI_W + LO_W;

   logic [CW-1:0] cnt;
   logic          no_wr;
   assign cnt   = {hi_rd[HI_W-1:0], lo_rd[LO_W-1:0]};
   assign no_wr = ~hi_wr & ~lo_wr;

   assert_lo_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_rd >> LO_W) == '0);

   assert_wrap_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt && no_wr) |=> (cnt != '0 || ovf_flag));

   assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ovf_flag);

   assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !(&cnt)) |=> !ovf_flag);

   assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && no_wr) |=> $stable(cnt));

   assert_gated_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !gate_pin && no_wr) |=> $stable(cnt));

   assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      no_wr |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1)));

   assert_hi_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> hi_rd[HI_W-1:0] == $past(wr_data[HI_W-1:0]));

   assert_lo_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr |=> lo_rd[LO_W-1:0] == $past(wr_data[LO_W-1:0]));
endmodule

bind gtc13_timer gtc13_timer_chk #(.HI_W(HI_W), .LO_W(LO_W), .BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .gate_en  (gate_en),
   .gate_pin (gate_pin),
   .hi_wr    (hi_wr),
   .lo_wr    (lo_wr),
   .wr_data  (wr_data),
   .ovf_clr  (ovf_clr),
   .hi_rd    (hi_rd),
   .lo_rd    (lo_rd),
   .ovf_flag (ovf_flag),
   .irq      (irq)
);

// File: tb/gtc13_timer_test.sv
`timescale 1ns/1ps
module gtc13_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0, gate_en = 1'b0, ext_sel = 1'b0;
   logic       gate_pin = 1'b0, cnt_pin = 1'b0;
   logic       hi_wr = 1'b0, lo_wr = 1'b0, ovf_clr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] hi_rd, lo_rd;
   logic       ovf_flag, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gtc13_timer uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en),
      .ext_sel(ext_sel), .gate_pin(gate_pin), .cnt_pin(cnt_pin),
      .hi_wr(hi_wr), .lo_wr(lo_wr), .wr_data(wr_data), .ovf_clr(ovf_clr),
      .hi_rd(hi_rd), .lo_rd(lo_rd), .ovf_flag(ovf_flag), .irq(irq)
   );

   // vector: [37:25] start, [24] run, [23] gate, [22] gate_pin,
   //         [21:14] periods of 12 clocks, [13] flag, [12:0] expected count
   localparam int NV = 7;
   localparam logic [37:0] VEC [NV] = '{
      {13'h0000, 1'b1, 1'b0, 1'b0, 8'd5, 1'b0, 13'h0005},  // R6
      {13'h001E, 1'b1, 1'b0, 1'b0, 8'd3, 1'b0, 13'h0021},  // R2 carry from bit 4
      {13'h0100, 1'b0, 1'b0, 1'b1, 8'd4, 1'b0, 13'h0100},  // R5 stopped
      {13'h0050, 1'b1, 1'b1, 1'b0, 8'd4, 1'b0, 13'h0050},  // R5 gate closed
      {13'h0050, 1'b1, 1'b1, 1'b1, 8'd4, 1'b0, 13'h0054},  // R5 gate open
      {13'h1FFE, 1'b1, 1'b0, 1'b0, 8'd4, 1'b1, 13'h0002},  // R3 wrap
      {13'h1FFF, 1'b1, 1'b1, 1'b1, 8'd1, 1'b1, 13'h0000}   // R3 exact wrap
   };

   function automatic int cnt_now();
      return int'({hi_rd, lo_rd[4:0]});
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [12:0] v);
      run_en = 1'b0;
      hi_wr = 1'b1; wr_data = v[12:5];
      tick(1);
      hi_wr = 1'b0; lo_wr = 1'b1; wr_data = {3'b111, v[4:0]};
      tick(1);
      lo_wr = 1'b0; ovf_clr = 1'b1;
      tick(1);
      ovf_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      tick(2);
      chk("R1 count in reset", cnt_now(), 0);
      chk("R1 flag in reset", int'(ovf_flag), 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 count after reset", cnt_now(), 0);
      chk("R1 irq after reset", int'(irq), 0);

      for (int i = 0; i < NV; i++) begin
         load(VEC[i][37:25]);
         chk("R2 lo pad after load", int'(lo_rd[7:5]), 0);
         gate_en = VEC[i][23]; gate_pin = VEC[i][22]; run_en = VEC[i][24];
         tick(12 * int'(VEC[i][21:14]));
         run_en = 1'b0;
         tick(1);
         chk($sformatf("R5/R6 vector %0d count", i), cnt_now(), int'(VEC[i][12:0]));
         chk($sformatf("R3 vector %0d flag", i), int'(ovf_flag), int'(VEC[i][13]));
         chk($sformatf("R3 vector %0d irq", i), int'(irq), int'(VEC[i][13]));
      end
      gate_en = 1'b0; gate_pin = 1'b0;

      // R4: flag stays without a clear
      tick(5);
      chk("R4 flag sticky", int'(ovf_flag), 1);

      // R4: clear and wrap together -> set, then clear
      load(13'h1FFF);
      hi_wr = 1'b1; wr_data = 8'hFF;   // flag set again by hand via wrap below
      tick(1);
      hi_wr = 1'b0;
      ovf_clr = 1'b1; run_en = 1'b1;
      for (int k = 0; k < 14 && cnt_now() != 0; k++) tick(1);
      chk("R4 wrap count", cnt_now(), 0);
      chk("R4 wrap beats clear", int'(ovf_flag), 1);
      tick(1);
      chk("R4 clear takes effect", int'(ovf_flag), 0);
      ovf_clr = 1'b0; run_en = 1'b0;

      // R8: write overrides step on every divider phase
      run_en = 1'b1;
      for (int k = 0; k < 12; k++) begin
         lo_wr = 1'b1; wr_data = 8'h0A;
         tick(1);
         chk("R8 write beats step", int'(lo_rd), 8'h0A);
      end
      lo_wr = 1'b0; run_en = 1'b0;

      // R8: stop and resume keeps count
      load(13'h000A);
      run_en = 1'b1; tick(24); run_en = 1'b0; tick(1);
      chk("R8 first run", cnt_now(), 13'h000C);
      tick(7);
      run_en = 1'b1; tick(36); run_en = 1'b0; tick(1);
      chk("R8 resume no clear", cnt_now(), 13'h000F);

      // R7: counter mode
      load(13'h0000);
      cnt_pin = 1'b0; ext_sel = 1'b1; run_en = 1'b1;
      tick(40);
      chk("R7 divider ignored", cnt_now(), 0);
      cnt_pin = 1'b1;
      tick(30);
      chk("R7 rise and level ignored", cnt_now(), 0);
      cnt_pin = 1'b0;
      tick(3);
      chk("R7 fall counted within 3", cnt_now(), 1);
      for (int k = 0; k < 6; k++) begin
         cnt_pin = 1'b1; tick(3);
         cnt_pin = 1'b0; tick(3);
      end
      tick(2);
      chk("R7 seven falls", cnt_now(), 7);
      run_en = 1'b0; ext_sel = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule